// File: doc/BRIEF.md
# Flat-Map Device Address Translator

This block sits between an accelerator's DMA engines and memory. It turns a 64-bit device-virtual address into a physical address through a single level of 64-bit leaf descriptors. Pages are 16 KB, so the low 14 bits of the address pass straight through as the page offset. The virtual page number picks a descriptor from a small on-block descriptor store.

A live descriptor holds only two things: the physical frame address and a valid flag in bit 63. The translator rejects a request in three cases: any upper 32 address bits are set, the address lies outside the 0xE0000000-byte window that starts at zero, or the selected descriptor is not valid. Each case returns its own cause code. Read and write requests are treated the same, because no protection is enforced.

Software maintains the store through a configuration port with three operations: write a descriptor, read one back, or unmap one, which clears it to zero. For simulation the store covers a reduced part of the window, and its depth is set by the parameter `IDX_W`. Requests flow through a two-state machine, IDLE and RESP. The IDLE to RESP transition happens when a request is accepted. The RESP to IDLE transition happens when the response is taken.

Top module: `dvt_translator`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0, and every descriptor reads back as zero.
- R2: A request accepted at a clock edge (req_valid and req_ready both 1) is answered with rsp_valid high from the next cycle. While rsp_valid is high and rsp_ready is low, rsp_pa and rsp_cause hold steady. req_ready is 0 whenever rsp_valid is 1.
- R3: A request with any of address bits 63:32 set returns cause 1 (HIGH_ADDR) and rsp_pa 0.
- R4: A request with bits 63:32 clear and bits 31:0 at or above 0xE0000000 returns cause 2 (OUT_OF_WINDOW) and rsp_pa 0.
- R5: A request to a page whose descriptor has bit 63 set returns cause 0 (OK). Its rsp_pa equals descriptor bits 62:14 placed at bits 62:14, the request's bits 13:0 at bits 13:0, and bit 63 zero.
- R6: A request inside the window returns cause 3 (NOT_MAPPED) and rsp_pa 0 in two cases: the selected descriptor has bit 63 clear, or the page number (address bits 31:14) is at or above 2^IDX_W.
- R7: The req_write input has no effect. A read and a write to the same address give the same response.
- R8: cfg_op 2 (unmap) sets the descriptor at cfg_idx to all zeros. Later translations of that page return cause 3.
- R9: cfg_op 0 (write) stores cfg_wdata with bits 13:0 forced to zero. cfg_op 1 (read) returns the stored descriptor on cfg_rdata with cfg_rvalid high one cycle after the request. cfg_op 3 changes nothing.
- R10: When more than one fault applies, the cause is chosen in this order: HIGH_ADDR first, then OUT_OF_WINDOW, then NOT_MAPPED.
- R11: When a request is accepted in the same cycle as a configuration write to its page, the request is translated with the descriptor as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator can accept a request |
| req_va | input | 64 | Device-virtual address |
| req_write | input | 1 | Request is a write (ignored) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 64 | Physical address, zero on a fault |
| rsp_cause | output | 2 | 0 OK, 1 HIGH_ADDR, 2 OUT_OF_WINDOW, 3 NOT_MAPPED |
| cfg_en | input | 1 | Configuration operation strobe |
| cfg_op | input | 2 | 0 write, 1 read, 2 unmap, 3 no-op |
| cfg_idx | input | IDX_W | Descriptor index (page number) |
| cfg_wdata | input | 64 | Descriptor value to write |
| cfg_rvalid | output | 1 | cfg_rdata carries a read result |
| cfg_rdata | output | 64 | Descriptor read back |

## Verification
A translation result is due in the first cycle after the clock edge that accepts the request. The bench drives inputs on the falling edge, waits one rising edge, and samples rsp_valid, rsp_pa and rsp_cause at the next falling edge. A configuration read result appears on cfg_rdata one edge after the operation, and the bench samples it at the following falling edge. The hold test leaves rsp_ready low for several cycles and compares the response at each falling edge with the value first seen.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
    localparam int VA_W   = 64;
    localparam int DESC_W = 64;

    typedef enum logic [1:0] {
        CAUSE_OK        = 2'd0,
        CAUSE_HIGH_ADDR = 2'd1,
        CAUSE_WINDOW    = 2'd2,
        CAUSE_NOT_MAP   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        CFG_WRITE = 2'd0,
        CFG_READ  = 2'd1,
        CFG_UNMAP = 2'd2,
        CFG_NOP   = 2'd3
    } cfg_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xl_state_e;
endpackage

// File: rtl/dvt_desc_store.sv
module dvt_desc_store
    import dvt_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int PAGE_BITS = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic [1:0]          cfg_op,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [DESC_W-1:0]   cfg_wdata,
    output logic                cfg_rvalid,
    output logic [DESC_W-1:0]   cfg_rdata,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [DESC_W-1:0]   lk_desc
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DESC_W-1:0] table_q [DEPTH];
    logic [DESC_W-1:0] wr_val;
    logic              do_write;
    logic              do_unmap;
    logic              unused_lowbits;

    assign do_write = cfg_en && (cfg_op == CFG_WRITE);
    assign do_unmap = cfg_en && (cfg_op == CFG_UNMAP);
    assign wr_val   = {cfg_wdata[DESC_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    assign unused_lowbits = ^cfg_wdata[PAGE_BITS-1:0];

    // lookup sees the value before any same-cycle update
    assign lk_desc = table_q[lk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
        end else if (do_write) begin
            table_q[cfg_idx] <= wr_val;
        end else if (do_unmap) begin
            table_q[cfg_idx] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_en && (cfg_op == CFG_READ);
            if (cfg_en && (cfg_op == CFG_READ)) cfg_rdata <= table_q[cfg_idx];
        end
    end

    AST_UNMAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        do_unmap |=> (table_q[$past(cfg_idx)] == '0)); // R8
    AST_WRITE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> (table_q[$past(cfg_idx)][PAGE_BITS-1:0] == '0)); // R9
endmodule

// File: rtl/dvt_addr_check.sv
module dvt_addr_check
    import dvt_pkg::*;
#(
    parameter int          IDX_W      = 6,
    parameter int          PAGE_BITS  = 14,
    parameter logic [31:0] WINDOW_TOP = 32'hE000_0000
) (
    input  logic [VA_W-1:0]   va,
    input  logic              is_write,
    input  logic [DESC_W-1:0] desc,
    output logic [IDX_W-1:0]  idx,
    output cause_e            cause,
    output logic [VA_W-1:0]   pa
);
    localparam int VPN_W = 32 - PAGE_BITS;

    logic [VPN_W-1:0] vpn;
    logic             high_bad;
    logic             window_bad;
    logic             beyond_store;
    logic             unused_ok;

    assign vpn          = va[31:PAGE_BITS];
    assign idx          = vpn[IDX_W-1:0];
    assign high_bad     = |va[VA_W-1:32];
    assign window_bad   = va[31:0] >= WINDOW_TOP;
    assign beyond_store = (vpn >> IDX_W) != '0;
    assign unused_ok    = ^{is_write, desc[PAGE_BITS-1:0]};

    always_comb begin
        cause = CAUSE_OK;
        pa    = '0;
        if (high_bad)                      cause = CAUSE_HIGH_ADDR;
        else if (window_bad)               cause = CAUSE_WINDOW;
        else if (beyond_store || !desc[DESC_W-1]) cause = CAUSE_NOT_MAP;
        else pa = {1'b0, desc[DESC_W-2:PAGE_BITS], va[PAGE_BITS-1:0]};
    end
endmodule

// File: rtl/dvt_resp_fsm.sv
module dvt_resp_fsm
    import dvt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    input  cause_e          nxt_cause,
    input  logic [VA_W-1:0] nxt_pa,
    output logic [VA_W-1:0] rsp_pa,
    output logic [1:0]      rsp_cause
);
    xl_state_e state_q, state_d;
    logic      fire;

    assign fire = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_pa    <= '0;
            rsp_cause <= CAUSE_OK;
        end else if (fire) begin
            rsp_pa    <= nxt_pa;
            rsp_cause <= nxt_cause;
        end
    end

    AST_ONE_CYCLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid); // R2
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_cause))); // R2
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2
endmodule

// File: rtl/dvt_translator.sv
module dvt_translator
    import dvt_pkg::*;
#(
    parameter int          IDX_W      = 6,
    parameter int          PAGE_BITS  = 14,
    parameter logic [31:0] WINDOW_TOP = 32'hE000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_va,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [63:0]      rsp_pa,
    output logic [1:0]       rsp_cause,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_op,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [63:0]      cfg_wdata,
    output logic             cfg_rvalid,
    output logic [63:0]      cfg_rdata
);
    logic [IDX_W-1:0]  lk_idx;
    logic [DESC_W-1:0] lk_desc;
    cause_e            nxt_cause;
    logic [VA_W-1:0]   nxt_pa;

    dvt_desc_store #(.IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .lk_idx(lk_idx), .lk_desc(lk_desc)
    );

    dvt_addr_check #(.IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS), .WINDOW_TOP(WINDOW_TOP)) u_check (
        .va(req_va), .is_write(req_write), .desc(lk_desc),
        .idx(lk_idx), .cause(nxt_cause), .pa(nxt_pa)
    );

    dvt_resp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .nxt_cause(nxt_cause), .nxt_pa(nxt_pa),
        .rsp_pa(rsp_pa), .rsp_cause(rsp_cause)
    );

    AST_HIGH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_va[63:32] != '0)) |=> (rsp_cause == 2'd1 && rsp_pa == '0)); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_cause != 2'd0 || rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0]))); // R5
    AST_WINDOW_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_va[63:32] == '0 && req_va[31:0] >= WINDOW_TOP)
        |=> (rsp_cause == 2'd2)); // R4
endmodule

// File: tb/tb_dvt_translator.sv
module tb_dvt_translator;
    localparam int IDX_W = 6;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [63:0]      req_va = '0;
    logic             req_write = 1'b0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b1;
    logic [63:0]      rsp_pa;
    logic [1:0]       rsp_cause;
    logic             cfg_en = 1'b0;
    logic [1:0]       cfg_op = 2'd3;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [63:0]      cfg_wdata = '0;
    logic             cfg_rvalid;
    logic [63:0]      cfg_rdata;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model [DEPTH];

    always #2 clk = ~clk;

    dvt_translator #(.IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_cause(rsp_cause),
        .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [65:0] expect_xlate(input logic [63:0] va);
        logic [17:0] vpn;
        logic [63:0] d;
        vpn = va[31:14];
        if (va[63:32] != 0)          return {2'd1, 64'd0};
        if (va[31:0] >= 32'hE0000000) return {2'd2, 64'd0};
        if (vpn >= DEPTH)            return {2'd3, 64'd0};
        d = model[vpn[IDX_W-1:0]];
        if (!d[63])                  return {2'd3, 64'd0};
        return {2'd0, 1'b0, d[62:14], va[13:0]};
    endfunction

    task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input string tag, input logic [63:0] va, input logic wr);
        logic [65:0] e;
        e = expect_xlate(va);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, req_ready, rsp_cause, rsp_pa}, {1'b1, 1'b0, e});
    endtask

    task automatic do_cfg(input logic [1:0] op, input int idx, input logic [63:0] wd);
        @(negedge clk);
        cfg_en = 1'b1; cfg_op = op; cfg_idx = idx[IDX_W-1:0]; cfg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
        if (op == 2'd0) model[idx] = {wd[63:14], 14'd0};
        if (op == 2'd2) model[idx] = '0;
    endtask

    task automatic cfg_read(input string tag, input int idx);
        do_cfg(2'd1, idx, '0);
        check(tag, {cfg_rvalid, cfg_rdata, 1'b0}, {1'b1, model[idx], 1'b0});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [65:0] held;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        void'($urandom(32'd7019));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready/valid", {64'd0, req_ready, rsp_valid}, {64'd0, 1'b1, 1'b0});
        cfg_read("R1 descriptor zero", 5);

        // R9 write with dirty low bits, read back masked
        do_cfg(2'd0, 5, 64'h8000_0001_2345_7FFF);
        cfg_read("R9 masked readback", 5);
        do_cfg(2'd3, 5, 64'h0);
        cfg_read("R9 nop keeps value", 5);

        // R5 valid translation, R7 read vs write
        do_req("R5 mapped", 64'h0001_6ABC, 1'b0);
        do_req("R7 write same page", 64'h0001_6ABC, 1'b1);

        // R3 / R10 priority
        do_req("R3 high bits", 64'h0000_0001_0001_6000, 1'b0);
        do_req("R10 high over window", 64'hFFFF_0000_E000_0000, 1'b1);
        // R4 window boundary
        do_req("R4 at window top", 64'h0000_0000_E000_0000, 1'b0);
        do_req("R4 last byte", 64'h0000_0000_FFFF_FFFF, 1'b0);
        do_req("R10 below top not mapped", 64'h0000_0000_DFFF_FFFF, 1'b0);
        // R6 beyond store and invalid descriptor
        do_req("R6 beyond store", 64'h0010_0000, 1'b0);
        do_req("R6 invalid desc", 64'h0000_C000, 1'b0);
        do_cfg(2'd0, 7, 64'h0000_0000_ABCD_C000);
        do_req("R6 bit63 clear", 64'h0001_C010, 1'b0);

        // R8 unmap
        do_cfg(2'd2, 5, '0);
        cfg_read("R8 unmap readback", 5);
        do_req("R8 unmapped fault", 64'h0001_6ABC, 1'b0);

        // R2 hold under backpressure
        do_cfg(2'd0, 9, 64'h8000_0000_1234_4000);
        @(negedge clk);
        req_valid = 1'b1; req_va = 64'h0002_4321; rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        held = {rsp_cause, rsp_pa};
        check("R2 first response", held, expect_xlate(64'h0002_4321));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 hold", {rsp_valid, req_ready, held}, {1'b1, 1'b0, rsp_cause, rsp_pa});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R2 release", {64'd0, rsp_valid, req_ready}, {64'd0, 1'b0, 1'b1});

        // R11 same-cycle write and request
        @(negedge clk);
        req_valid = 1'b1; req_va = 64'h0000_C123;
        cfg_en = 1'b1; cfg_op = 2'd0; cfg_idx = 3; cfg_wdata = 64'h8000_0000_5555_8000;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; cfg_en = 1'b0;
        check("R11 old descriptor", {rsp_cause, rsp_pa}, {2'd3, 64'd0});
        model[3] = 64'h8000_0000_5555_8000;
        do_req("R11 new descriptor", 64'h0000_C123, 1'b0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            int sel;
            logic [63:0] va;
            sel = $urandom_range(0, 9);
            if (sel < 2) begin
                do_cfg(2'd0, $urandom_range(0, DEPTH-1),
                       {1'($urandom_range(0, 3) != 0), 31'($urandom), 32'($urandom)});
            end else if (sel == 2) begin
                do_cfg(2'd2, $urandom_range(0, DEPTH-1), '0);
            end else begin
                va = {32'd0, 6'd0, 26'($urandom)};
                if (sel == 3) va[63:32] = 32'($urandom_range(1, 255));
                if (sel == 4) va[31:0]  = 32'hE000_0000 + 32'($urandom_range(0, 32'h1FFF_FFFF));
                if (sel == 5) va[31:0]  = 32'($urandom);
                do_req("R5/R6 random", va, 1'($urandom));
            end
        end
        finish_run();
    end
endmodule